// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block merges the reset sources of a small microcontroller core into a single registered internal reset. The sources are a raw power-on pulse, a brown-out detector, an active-low external reset pin and a watchdog expiry strobe. After power-on or brown-out, a power-up delay counter keeps the core in reset for a fixed number of clock cycles. This counter depends only on the power-on and brown-out sources. The reset pin has no effect on it. If the pin is held low for longer than the delay, internal reset ends as soon as the pin is released.

A four-bit flag register records what caused the last reset or wake event. Bit 3 is the time-out flag and bit 2 is the power-down flag. Bit 1 is the active-low power-on flag and bit 0 is the active-low brown-out flag. Software can rewrite bits 1 and 0 through a small write port. A watchdog expiry during sleep does not reset the core. It gives a one-cycle wake strobe instead. The power-on pulse acts as the block's own reset.

Top module: `reset_cause_seq`

## Requirements
- R1: While `porPulse` is high, `intReset` is 1 and `causeFlags` reads 4'b1101 (time-out 1, power-down 1, power-on flag 0, brown-out flag modelled as 1).
- R2: With `timerDisable` = 0, `intReset` falls on the DELAY-th rising edge after `porPulse` is first sampled low. With `timerDisable` = 1, it falls on the first such edge.
- R3: The reset pin passes through two flops. If the pin is held low through power-on until after the delay has expired, `intReset` falls on the third edge after the pin is released.
- R4: With `borEnable` nonzero, a high `borDetect` asserts `intReset`, clears bit 0, sets bits 3 and 2, and keeps bit 1. After `borDetect` falls, the same delay as in R2 applies.
- R5: With `borEnable` = 2'b00, `borDetect` changes neither `intReset` nor `causeFlags`.
- R6: A cycle with `wrEn` high and no power-on or brown-out active loads bit 1 from `wrData[1]` and bit 0 from `wrData[0]`.
- R7: A watchdog expiry while `sleepMode` is 0 asserts `intReset` for exactly one cycle and clears bit 3. It leaves bits 2..0 unchanged and gives no wake strobe.
- R8: A watchdog expiry while `sleepMode` is 1 pulses `wakeStrobe` for one cycle on the next edge and clears bits 3 and 2. It does not assert `intReset`.
- R9: Driving the reset pin low asserts `intReset` on the third edge. If `sleepMode` is 1, bit 3 is set and bit 2 is cleared. If `sleepMode` is 0, no flag changes.
- R10: Bit 1 is changed only by a power-on pulse or a software write. Brown-out, watchdog and pin events leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porPulse | input | 1 | Raw power-on pulse, active high; also resets the block |
| borDetect | input | 1 | Brown-out detector output, active high |
| borEnable | input | 2 | Brown-out enable field; 2'b00 disables |
| resetPinN | input | 1 | External reset pin, active low, asynchronous |
| wdtExpire | input | 1 | Watchdog expiry strobe |
| sleepMode | input | 1 | Core is in sleep |
| timerDisable | input | 1 | 1 skips the power-up delay |
| wrEn | input | 1 | Software write strobe for flag bits 1..0 |
| wrData | input | 2 | Write data: [1] power-on flag, [0] brown-out flag |
| intReset | output | 1 | Internal reset to the core, active high |
| wakeStrobe | output | 1 | One-cycle wake-up from sleep |
| causeFlags | output | 4 | {time-out, power-down, power-on, brown-out} |

## Verification
The bound checker checks several behaviours on every cycle:
- the flag pattern and reset level right after power-on;
- an enabled brown-out clearing its flag and raising reset;
- a wake strobe coinciding with cleared time-out and power-down flags;
- the power-on flag holding steady without a power-on pulse or write;
- a pin held low for three samples reaching reset.

Only the bench scenarios can show cycle-exact timing:
- the edge counts at which reset ends after power-on, after brown-out and after a late pin release;
- that a watchdog reset lasts one cycle;
- that a disabled brown-out and a pin reset during run leave every flag untouched.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;

  localparam int FlagCount = 4;
  localparam int BrownIdx  = 0;
  localparam int PowerIdx  = 1;
  localparam int DownIdx   = 2;
  localparam int TimeIdx   = 3;

  // flag image forced by a power-on event: {time, down, power, brown}
  localparam logic [FlagCount-1:0] PorImage = 4'b1101;

  typedef struct packed {
    logic evPor;
    logic evBor;
    logic evWdtRst;
    logic evWdtWake;
    logic evPinSleep;
    logic swWrite;
    logic loadTimer;
    logic assertReq;
  } seqStrobe_t;

endpackage

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import reset_cause_pkg::*;
(
  input  logic       clk,
  input  logic       porPulse,
  input  logic       borDetect,
  input  logic [1:0] borEnable,
  input  logic       resetPinN,
  input  logic       wdtExpire,
  input  logic       sleepMode,
  input  logic       wrEn,
  output seqStrobe_t strobes
);

  logic pinMeta;
  logic pinSync;
  logic borActive;
  logic quiet;
  logic pinFall;

  // two-flop synchronizer for the asynchronous pin
  always_ff @(posedge clk) begin
    pinMeta <= resetPinN;
    pinSync <= pinMeta;
  end

  always_comb begin
    borActive = borDetect && (borEnable != 2'b00);
    quiet     = !porPulse && !borActive;
    // falling transition seen between the two synchronizer stages
    pinFall   = pinSync && !pinMeta;

    strobes.evPor      = porPulse;
    strobes.evBor      = borActive && !porPulse;
    strobes.evWdtRst   = quiet && wdtExpire && !sleepMode;
    strobes.evWdtWake  = quiet && wdtExpire && sleepMode;
    strobes.evPinSleep = quiet && !wdtExpire && pinFall && sleepMode;
    strobes.swWrite    = quiet && wrEn;
    strobes.loadTimer  = porPulse || borActive;
    strobes.assertReq  = porPulse || borActive || !pinSync ||
                         (quiet && wdtExpire && !sleepMode);
  end

endmodule

// File: rtl/reset_cause_dp.sv
module reset_cause_dp
  import reset_cause_pkg::*;
#(
  parameter int DELAY = 16
) (
  input  logic                 clk,
  input  seqStrobe_t           strobes,
  input  logic                 timerDisable,
  input  logic [1:0]           wrData,
  output logic                 intReset,
  output logic                 wakeStrobe,
  output logic [FlagCount-1:0] causeFlags
);

  localparam int CntW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);
  localparam logic [CntW-1:0] LoadFull = CntW'(DELAY);

  logic [CntW-1:0]      delayCnt;
  logic [CntW-1:0]      delayNext;
  logic [FlagCount-1:0] flagsNext;

  always_comb begin
    if (strobes.loadTimer) begin
      delayNext = timerDisable ? '0 : LoadFull;
    end else if (delayCnt != '0) begin
      delayNext = delayCnt - 1'b1;
    end else begin
      delayNext = '0;
    end
  end

  always_comb begin
    flagsNext = causeFlags;
    if (strobes.evPor) begin
      flagsNext = PorImage;
    end else if (strobes.evBor) begin
      flagsNext[BrownIdx] = 1'b0;
      flagsNext[DownIdx]  = 1'b1;
      flagsNext[TimeIdx]  = 1'b1;
    end else begin
      if (strobes.swWrite) begin
        flagsNext[BrownIdx] = wrData[0];
        flagsNext[PowerIdx] = wrData[1];
      end
      if (strobes.evWdtRst) begin
        flagsNext[TimeIdx] = 1'b0;
      end else if (strobes.evWdtWake) begin
        flagsNext[TimeIdx] = 1'b0;
        flagsNext[DownIdx] = 1'b0;
      end else if (strobes.evPinSleep) begin
        flagsNext[TimeIdx] = 1'b1;
        flagsNext[DownIdx] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    delayCnt   <= delayNext;
    intReset   <= strobes.assertReq || (delayNext != '0);
    wakeStrobe <= strobes.evWdtWake;
    causeFlags <= flagsNext;
  end

endmodule

// File: rtl/reset_cause_seq.sv
module reset_cause_seq
  import reset_cause_pkg::*;
#(
  parameter int DELAY = 16
) (
  input  logic       clk,
  input  logic       porPulse,
  input  logic       borDetect,
  input  logic [1:0] borEnable,
  input  logic       resetPinN,
  input  logic       wdtExpire,
  input  logic       sleepMode,
  input  logic       timerDisable,
  input  logic       wrEn,
  input  logic [1:0] wrData,
  output logic       intReset,
  output logic       wakeStrobe,
  output logic [3:0] causeFlags
);

  seqStrobe_t strobes;

  reset_cause_ctrl u_ctrl (
    .clk       (clk),
    .porPulse  (porPulse),
    .borDetect (borDetect),
    .borEnable (borEnable),
    .resetPinN (resetPinN),
    .wdtExpire (wdtExpire),
    .sleepMode (sleepMode),
    .wrEn      (wrEn),
    .strobes   (strobes)
  );

  reset_cause_dp #(.DELAY(DELAY)) u_dp (
    .clk          (clk),
    .strobes      (strobes),
    .timerDisable (timerDisable),
    .wrData       (wrData),
    .intReset     (intReset),
    .wakeStrobe   (wakeStrobe),
    .causeFlags   (causeFlags)
  );

endmodule

// File: rtl/reset_cause_seq_chk.sv
module reset_cause_seq_chk (
  input logic       clk,
  input logic       porPulse,
  input logic       borDetect,
  input logic [1:0] borEnable,
  input logic       resetPinN,
  input logic       wrEn,
  input logic       intReset,
  input logic       wakeStrobe,
  input logic [3:0] causeFlags
);

  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (porPulse) armed <= 1'b1;
  end

  // R1
  por_image_chk: assert property (@(posedge clk) disable iff (porPulse || !armed)
    $fell(porPulse) |-> (intReset && causeFlags == 4'b1101));

  // R4
  bor_flag_chk: assert property (@(posedge clk) disable iff (porPulse || !armed)
    (borDetect && borEnable != 2'b00) |=> (intReset && !causeFlags[0]));

  // R8
  wake_flags_chk: assert property (@(posedge clk) disable iff (porPulse || !armed)
    wakeStrobe |-> (causeFlags[3:2] == 2'b00));

  // R10
  power_flag_hold_chk: assert property (@(posedge clk) disable iff (porPulse || !armed)
    (!$past(porPulse) && !$past(wrEn)) |-> $stable(causeFlags[1]));

  // R9
  pin_reset_chk: assert property (@(posedge clk) disable iff (porPulse || !armed)
    (!resetPinN && $past(!resetPinN) && $past(!resetPinN, 2)) |=> intReset);

endmodule

bind reset_cause_seq reset_cause_seq_chk u_chk (
  .clk        (clk),
  .porPulse   (porPulse),
  .borDetect  (borDetect),
  .borEnable  (borEnable),
  .resetPinN  (resetPinN),
  .wrEn       (wrEn),
  .intReset   (intReset),
  .wakeStrobe (wakeStrobe),
  .causeFlags (causeFlags)
);

// File: tb/reset_cause_seq_bench.sv
module reset_cause_seq_bench;

  localparam int D = 6;

  logic       clk = 1'b0;
  logic       porPulse = 1'b1;
  logic       borDetect = 1'b0;
  logic [1:0] borEnable = 2'b01;
  logic       resetPinN = 1'b1;
  logic       wdtExpire = 1'b0;
  logic       sleepMode = 1'b0;
  logic       timerDisable = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrData = 2'b00;
  logic       intReset;
  logic       wakeStrobe;
  logic [3:0] causeFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reset_cause_seq #(.DELAY(D)) u_reset_cause_seq (
    .clk(clk), .porPulse(porPulse), .borDetect(borDetect), .borEnable(borEnable),
    .resetPinN(resetPinN), .wdtExpire(wdtExpire), .sleepMode(sleepMode),
    .timerDisable(timerDisable), .wrEn(wrEn), .wrData(wrData),
    .intReset(intReset), .wakeStrobe(wakeStrobe), .causeFlags(causeFlags)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic measure(output int k);
    k = 0;
    for (int i = 1; i <= 60; i++) begin
      step(1);
      if (!intReset) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic powerOn(input logic tdis);
    int k;
    timerDisable = tdis;
    porPulse = 1'b1;
    step(3);
    check("R1 reset level", int'(intReset), 1);
    check("R1 flag image", int'(causeFlags), 4'b1101);
    porPulse = 1'b0;
    measure(k);
    check("R2 release edge", k, tdis ? 1 : D);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k;
    step(1);
    // R1, R2: power-on with the delay timer on and off
    for (int t = 0; t < 2; t++) powerOn(t[0]);
    powerOn(1'b0);

    // R3: pin held low through power-on past the delay
    resetPinN = 1'b0;
    porPulse = 1'b1;
    step(3);
    porPulse = 1'b0;
    step(D + 3);
    check("R3 pin holds reset", int'(intReset), 1);
    resetPinN = 1'b1;
    measure(k);
    check("R3 release after pin", k, 3);

    // R6: software write sets the active-low flags
    wrEn = 1'b1; wrData = 2'b11;
    step(1);
    wrEn = 1'b0;
    check("R6 write", int'(causeFlags), 4'b1111);

    // R7: watchdog reset while running
    wdtExpire = 1'b1;
    step(1);
    wdtExpire = 1'b0;
    check("R7 reset pulse", int'(intReset), 1);
    check("R7 flags", int'(causeFlags), 4'b0111);
    check("R7 no wake", int'(wakeStrobe), 0);
    step(1);
    check("R7 one cycle", int'(intReset), 0);

    // R4, R10: brown-out for each enabled setting
    for (int e = 1; e < 4; e++) begin
      wrEn = 1'b1; wrData = 2'b11;
      step(1);
      wrEn = 1'b0;
      borEnable = e[1:0];
      borDetect = 1'b1;
      step(2);
      check("R4 reset", int'(intReset), 1);
      check("R4 R10 flags", int'(causeFlags), 4'b1110);
      borDetect = 1'b0;
      measure(k);
      check("R4 delay", k, D);
    end

    // R5: brown-out disabled
    borEnable = 2'b00;
    borDetect = 1'b1;
    step(3);
    check("R5 no reset", int'(intReset), 0);
    check("R5 flags kept", int'(causeFlags), 4'b1110);
    borDetect = 1'b0;
    borEnable = 2'b01;

    // R8: watchdog wake from sleep
    wrEn = 1'b1; wrData = 2'b11;
    step(1);
    wrEn = 1'b0;
    sleepMode = 1'b1;
    wdtExpire = 1'b1;
    step(1);
    wdtExpire = 1'b0;
    check("R8 wake", int'(wakeStrobe), 1);
    check("R8 no reset", int'(intReset), 0);
    check("R8 R10 flags", int'(causeFlags), 4'b0011);
    step(1);
    check("R8 one cycle", int'(wakeStrobe), 0);

    // R9: pin reset during sleep
    resetPinN = 1'b0;
    step(3);
    check("R9 sleep reset", int'(intReset), 1);
    check("R9 sleep flags", int'(causeFlags), 4'b1011);
    resetPinN = 1'b1;
    step(3);
    check("R9 sleep release", int'(intReset), 0);
    sleepMode = 1'b0;

    // R9: pin reset during run leaves flags alone
    resetPinN = 1'b0;
    step(3);
    check("R9 run reset", int'(intReset), 1);
    check("R9 R10 run flags", int'(causeFlags), 4'b1011);
    resetPinN = 1'b1;
    step(3);
    check("R9 run release", int'(intReset), 0);

    // R6: write with other values
    for (int w = 0; w < 4; w++) begin
      wrEn = 1'b1; wrData = w[1:0];
      step(1);
      wrEn = 1'b0;
      check("R6 write sweep", int'(causeFlags[1:0]), w);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule